// File: doc/BRIEF.md
# Dynamic Bus Sizing Master Sequencer

This block takes one operand request from inside the chip (a byte, a word or a long word, to be read or written at a start address) and carries it out as a series of external bus cycles. Each cycle begins as if the responding port were 16 bits wide. The slave's two-wire acknowledge code then tells the sequencer whether to keep waiting, whether the port turned out to be 8 or 16 bits wide, or whether the cycle failed. After each accepted cycle the sequencer plans the remaining bytes again, moves the address on, and starts the next cycle after one idle clock.

Write bytes are steered onto fixed lanes, most significant operand byte first. Read bytes are shifted into an accumulator in the same order, so a finished read is right-aligned and zero-extended. A bus-error input, or the reserved acknowledge code, ends the operand at once with an error flag. During an interrupt-acknowledge cycle an autovector input ends the operand with an autovector flag. In every other cycle type that input is ignored.

The request side is valid/ready. A request is taken only on a clock where both are high, and `req_ready` stays low until the response has been taken. The response side is valid/ready as well. `rsp_valid` and all response fields stay fixed while `rsp_ready` is low, so the consumer can hold off for any number of clocks. The bus inputs are assumed to be synchronous and settled before each rising edge. They are sampled once per clock.

Top module: `bus_sizing_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `bus_strobe` is 0 and `rsp_valid` is 0.
- R2: While a cycle is open and the acknowledge pair {`ack_hi_n`,`ack_lo_n`} is 2'b11 with no other termination, the cycle stays open and `bus_addr` holds its value.
- R3: An acknowledge of 2'b01 means a 16-bit port. When the address is even and at least two bytes remain, two bytes move and the address advances by 2. A long word at an even address takes two cycles. `bus_siz` shows the bytes still to move (2'b00 means four), and the response is valid at the edge that accepts the final cycle.
- R4: An acknowledge of 2'b10 means an 8-bit port. Exactly one byte moves on bits [15:8] and the address advances by 1, so a long word takes four cycles.
- R5: On writes, `bus_dout` carries {next byte, byte after it} when a byte pair fits. Otherwise it carries the next byte on both lanes. A byte is always counted OP0 (most significant) first.
- R6: Read bytes are assembled most significant first and returned right-aligned with zero fill: byte in [7:0], word in [15:0], long word in [31:0]. Writes return 0.
- R7: On a 16-bit port, a cycle at an odd address moves one byte on bits [7:0].
- R8: Bus error (`berr_n` low) ends the operand at that edge with `rsp_berr`=1. It takes priority over any acknowledge, and no further cycles run.
- R9: The reserved acknowledge code 2'b00 ends the operand with `rsp_berr`=1.
- R10: In an interrupt-acknowledge cycle (`bus_iack`=1), `avec_n` low ends the operand with `rsp_avec`=1. In any other cycle `avec_n` has no effect.
- R11: Between two cycles of one operand, `bus_strobe` is low for exactly one clock.
- R12: `req_ready` is low from acceptance until the response handshake. `rsp_valid` and `rsp_rdata` hold while `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Operand request valid |
| req_ready | output | 1 | Sequencer idle, request accepted on valid&ready |
| req_size | input | 2 | 00 byte, 01 word, 10/11 long word |
| req_addr | input | ADDR_W | Start address |
| req_write | input | 1 | 1 write, 0 read |
| req_iack | input | 1 | Request is an interrupt-acknowledge read |
| req_wdata | input | 32 | Write operand, right-aligned |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Assembled read operand |
| rsp_berr | output | 1 | Operand ended by bus error or reserved code |
| rsp_avec | output | 1 | Operand ended by autovector |
| bus_strobe | output | 1 | External cycle open |
| bus_addr | output | ADDR_W | Cycle address |
| bus_read | output | 1 | 1 read cycle, 0 write cycle |
| bus_iack | output | 1 | Cycle is interrupt acknowledge |
| bus_siz | output | 2 | Bytes left to move, 00 = four |
| bus_dout | output | 16 | Write data lanes |
| bus_dout_en | output | 1 | Write data driven |
| bus_din | input | 16 | Read data lanes |
| ack_hi_n | input | 1 | Acknowledge, upper wire (active low) |
| ack_lo_n | input | 1 | Acknowledge, lower wire (active low) |
| berr_n | input | 1 | Bus error (active low) |
| avec_n | input | 1 | Autovector (active low) |

## Verification
A cycle opens at the clock edge that takes the request, or one idle clock after the previous cycle closed. It closes at the first edge where the slave model shows a termination, after the number of wait clocks the model was told to insert. The response is valid from the edge that closes the final cycle. The slave model drives the bus on falling edges and records every address, size code and lane on the falling edge before the closing edge. The bench checks the idle gap and `rsp_valid` on the falling edge just after it, and compares response fields from a queue on the falling edge before the handshake edge.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
  localparam int OP_W  = 32;
  localparam int LANE_W = 16;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b01;

  typedef enum logic [2:0] {
    TK_WAIT,
    TK_PORT8,
    TK_PORT16,
    TK_ERR,
    TK_AVEC
  } term_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BUS,
    ST_GAP,
    ST_RESP
  } st_e;
endpackage

// File: rtl/bsz_term_decode.sv
module bsz_term_decode
  import bsz_pkg::*;
(
  input  logic  ack_hi_n,
  input  logic  ack_lo_n,
  input  logic  berr_n,
  input  logic  avec_n,
  input  logic  iack,
  output term_e kind
);
  // bus error outranks everything; autovector counts only in iack cycles
  always_comb begin
    if (!berr_n)                kind = TK_ERR;
    else if (iack && !avec_n)   kind = TK_AVEC;
    else begin
      unique case ({ack_hi_n, ack_lo_n})
        2'b11:   kind = TK_WAIT;
        2'b10:   kind = TK_PORT8;
        2'b01:   kind = TK_PORT16;
        default: kind = TK_ERR;   // reserved code
      endcase
    end
  end
endmodule

// File: rtl/bsz_lane_steer.sv
module bsz_lane_steer
  import bsz_pkg::*;
(
  input  logic              odd,
  input  logic [2:0]        rem,
  input  logic              port16,
  input  logic [LANE_W-1:0] wtop,
  input  logic [LANE_W-1:0] din,
  output logic [1:0]        take,
  output logic [LANE_W-1:0] dout,
  output logic [LANE_W-1:0] rchunk
);
  logic pair;
  assign pair = !odd && (rem >= 3'd2);

  // assume a 16-bit port: a pair when it fits, else the byte on both lanes
  assign dout = pair ? wtop : {wtop[LANE_W-1 -: 8], wtop[LANE_W-1 -: 8]};

  always_comb begin
    if (port16 && pair) begin
      take   = 2'd2;
      rchunk = din;
    end else if (port16 && odd) begin
      take   = 2'd1;
      rchunk = {8'h00, din[7:0]};
    end else begin
      take   = 2'd1;
      rchunk = {8'h00, din[LANE_W-1 -: 8]};
    end
  end
endmodule

// File: rtl/bus_sizing_seq.sv
module bus_sizing_seq
  import bsz_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_iack,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_berr,
  output logic              rsp_avec,
  output logic              bus_strobe,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_read,
  output logic              bus_iack,
  output logic [1:0]        bus_siz,
  output logic [15:0]       bus_dout,
  output logic              bus_dout_en,
  input  logic [15:0]       bus_din,
  input  logic              ack_hi_n,
  input  logic              ack_lo_n,
  input  logic              berr_n,
  input  logic              avec_n
);
  st_e               st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        rem_q;
  logic [OP_W-1:0]   wbuf_q, acc_q;
  logic              wr_q, iack_q, err_q, av_q;

  term_e             kind;
  logic [1:0]        take;
  logic [LANE_W-1:0] lane_out, rchunk;
  logic [2:0]        init_rem;
  logic [OP_W-1:0]   init_wbuf;

  bsz_term_decode u_term (
    .ack_hi_n (ack_hi_n),
    .ack_lo_n (ack_lo_n),
    .berr_n   (berr_n),
    .avec_n   (avec_n),
    .iack     (iack_q),
    .kind     (kind)
  );

  bsz_lane_steer u_steer (
    .odd    (addr_q[0]),
    .rem    (rem_q),
    .port16 (kind == TK_PORT16),
    .wtop   (wbuf_q[OP_W-1 -: LANE_W]),
    .din    (bus_din),
    .take   (take),
    .dout   (lane_out),
    .rchunk (rchunk)
  );

  // left-align the write operand so OP0 sits in the top byte
  always_comb begin
    unique case (req_size)
      SZ_BYTE: begin init_rem = 3'd1; init_wbuf = {req_wdata[7:0], 24'h0};  end
      SZ_WORD: begin init_rem = 3'd2; init_wbuf = {req_wdata[15:0], 16'h0}; end
      default: begin init_rem = 3'd4; init_wbuf = req_wdata;                end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      rem_q  <= 3'd0;
      wbuf_q <= '0;
      acc_q  <= '0;
      wr_q   <= 1'b0;
      iack_q <= 1'b0;
      err_q  <= 1'b0;
      av_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          rem_q  <= init_rem;
          wbuf_q <= init_wbuf;
          acc_q  <= '0;
          wr_q   <= req_write;
          iack_q <= req_iack;
          err_q  <= 1'b0;
          av_q   <= 1'b0;
          st_q   <= ST_BUS;
        end
        ST_BUS: begin
          unique case (kind)
            TK_WAIT: ;
            TK_ERR:  begin err_q <= 1'b1; st_q <= ST_RESP; end
            TK_AVEC: begin av_q  <= 1'b1; st_q <= ST_RESP; end
            default: begin
              addr_q <= addr_q + {{(ADDR_W-2){1'b0}}, take};
              rem_q  <= rem_q - {1'b0, take};
              wbuf_q <= (take == 2'd2) ? (wbuf_q << 16) : (wbuf_q << 8);
              if (!wr_q)
                acc_q <= (take == 2'd2) ? {acc_q[15:0], rchunk}
                                        : {acc_q[23:0], rchunk[7:0]};
              st_q <= (rem_q == {1'b0, take}) ? ST_RESP : ST_GAP;
            end
          endcase
        end
        ST_GAP:  st_q <= ST_BUS;
        ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (st_q == ST_IDLE);
  assign rsp_valid   = (st_q == ST_RESP);
  assign rsp_rdata   = acc_q;
  assign rsp_berr    = err_q;
  assign rsp_avec    = av_q;
  assign bus_strobe  = (st_q == ST_BUS);
  assign bus_addr    = addr_q;
  assign bus_read    = !wr_q;
  assign bus_iack    = iack_q;
  assign bus_siz     = rem_q[1:0];
  assign bus_dout_en = bus_strobe && wr_q;
  assign bus_dout    = bus_dout_en ? lane_out : '0;
endmodule

// File: rtl/bsz_checker.sv
module bsz_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              bus_strobe,
  input logic              bus_iack,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              ack_hi_n,
  input logic              ack_lo_n,
  input logic              berr_n,
  input logic              avec_n,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_berr,
  input logic              rsp_avec,
  input logic [31:0]       rsp_rdata
);
  logic avec_hit, idle_code;
  assign avec_hit  = bus_iack && !avec_n;
  assign idle_code = ack_hi_n && ack_lo_n && berr_n && !avec_hit;

  p_wait_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe && idle_code |=> bus_strobe && $stable(bus_addr));

  p_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe && !idle_code |=> !bus_strobe);

  p_berr_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe && !berr_n |=> rsp_valid && rsp_berr);

  p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe && berr_n && !avec_hit && !ack_hi_n && !ack_lo_n
      |=> rsp_valid && rsp_berr);

  p_avec_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe && berr_n && avec_hit |=> rsp_valid && rsp_avec);

  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe || rsp_valid) |-> !req_ready);
endmodule

bind bus_sizing_seq bsz_checker #(.ADDR_W(ADDR_W)) u_bsz_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .bus_strobe (bus_strobe),
  .bus_iack   (bus_iack),
  .bus_addr   (bus_addr),
  .ack_hi_n   (ack_hi_n),
  .ack_lo_n   (ack_lo_n),
  .berr_n     (berr_n),
  .avec_n     (avec_n),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_berr   (rsp_berr),
  .rsp_avec   (rsp_avec),
  .rsp_rdata  (rsp_rdata)
);

// File: tb/test_bus_sizing_seq.sv
module test_bus_sizing_seq;
  localparam int AW = 24;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, req_write = 0, req_iack = 0;
  logic [1:0] req_size = 0;
  logic [AW-1:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic rsp_valid, rsp_ready = 1, rsp_berr, rsp_avec;
  logic [31:0] rsp_rdata;
  logic bus_strobe, bus_read, bus_iack, bus_dout_en;
  logic [AW-1:0] bus_addr;
  logic [1:0] bus_siz;
  logic [15:0] bus_dout, bus_din = 0;
  logic ack_hi_n = 1, ack_lo_n = 1, berr_n = 1, avec_n = 1;

  always #10 clk = ~clk;   // 50 MHz

  bus_sizing_seq #(.ADDR_W(AW)) i_bus_sizing_seq (.*);

  typedef struct { logic [31:0] rd; bit berr; bit avec; bit chk_data; } item_t;
  item_t sb[$];

  int total = 0, bad = 0;
  logic [7:0] mem [64];

  // slave model configuration
  bit port16; int nwait, berr_at, res_at, avec_mode;
  int wcnt, cyc; logic [AW-1:0] exp_addr; int exp_rem;
  bit prev_resp, prev_final;

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // slave: drives on falling edges
  always @(negedge clk) if (rst_n) begin
    if (prev_resp) begin
      chk(!bus_strobe, "R11 gap", bus_strobe, 0);
      if (prev_final) chk(rsp_valid, "R3 rsp due", rsp_valid, 1);
    end
    prev_resp = 0; prev_final = 0;
    if (!bus_strobe) begin
      ack_hi_n = 1; ack_lo_n = 1; berr_n = 1; wcnt = 0;
      avec_n = (avec_mode == 2) ? 1'b0 : 1'b1;
    end else if (wcnt < nwait) begin
      wcnt++;
      chk(bus_addr == exp_addr, "R2 addr hold", bus_addr, exp_addr);
    end else begin
      prev_resp = 1;
      if (cyc == berr_at) begin
        berr_n = 0; ack_hi_n = 1; ack_lo_n = 0; prev_final = 1;
      end else if (cyc == res_at) begin
        ack_hi_n = 0; ack_lo_n = 0; prev_final = 1;
      end else if (avec_mode == 1 && bus_iack) begin
        avec_n = 0; prev_final = 1;
      end else begin
        automatic int tk = (port16 && !bus_addr[0] && exp_rem >= 2) ? 2 : 1;
        automatic logic [5:0] a = bus_addr[5:0];
        chk(bus_addr == exp_addr, "R3/R4 addr", bus_addr, exp_addr);
        chk(bus_siz == exp_rem[1:0], "R3 siz", bus_siz, exp_rem[1:0]);
        if (port16) begin
          ack_hi_n = 0; ack_lo_n = 1;
          bus_din = {mem[{a[5:1], 1'b0}], mem[{a[5:1], 1'b1}]};
          if (!bus_read) begin
            if (tk == 2) begin mem[a] = bus_dout[15:8]; mem[a+6'd1] = bus_dout[7:0]; end
            else if (a[0]) mem[a] = bus_dout[7:0];
            else mem[a] = bus_dout[15:8];
          end
        end else begin
          ack_hi_n = 1; ack_lo_n = 0;
          bus_din = {mem[a], 8'hA5};
          if (!bus_read) mem[a] = bus_dout[15:8];
        end
        exp_addr = exp_addr + AW'(tk); exp_rem -= tk;
        prev_final = (exp_rem == 0);
      end
      cyc++;
    end
  end

  // monitor: scoreboard compare on the falling edge before the handshake
  always @(negedge clk) if (rst_n && rsp_valid && rsp_ready) begin
    if (sb.size() == 0) chk(0, "R12 unexpected rsp", 1, 0);
    else begin
      automatic item_t it = sb.pop_front();
      chk(rsp_berr == it.berr, "R8/R9 berr flag", rsp_berr, it.berr);
      chk(rsp_avec == it.avec, "R10 avec flag", rsp_avec, it.avec);
      if (it.chk_data) chk(rsp_rdata == it.rd, "R6 rdata", rsp_rdata, it.rd);
    end
  end

  task automatic run_op(input logic [1:0] sz, input logic [AW-1:0] a, input bit wr,
                        input bit ia, input logic [31:0] wd, input int exp_cyc,
                        input bit ck, input bit eb, input bit ea, input int hold,
                        input string tag);
    automatic int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    automatic item_t it;
    automatic logic [31:0] held;
    it.rd = 0;
    if (!wr) for (int i = 0; i < n; i++) it.rd = (it.rd << 8) | 32'(mem[(a[5:0] + 6'(i))]);
    it.berr = eb; it.avec = ea; it.chk_data = ck;
    sb.push_back(it);
    exp_addr = a; exp_rem = n; cyc = 0;
    @(negedge clk);
    rsp_ready = (hold == 0);
    chk(req_ready, {tag, " R12 idle ready"}, req_ready, 1);
    req_valid = 1; req_size = sz; req_addr = a; req_write = wr; req_iack = ia; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, {tag, " R12 busy"}, req_ready, 0);
    if (hold > 0) begin
      while (!rsp_valid) @(negedge clk);
      held = rsp_rdata;
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        chk(rsp_valid && rsp_rdata == held, {tag, " R12 hold"}, rsp_rdata, held);
      end
      rsp_ready = 1;
    end
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(cyc == exp_cyc, {tag, " cycle count"}, cyc, exp_cyc);
    if (wr && !eb)
      for (int i = 0; i < n; i++)
        chk(mem[a[5:0] + 6'(i)] == wd[8*(n-1-i) +: 8], {tag, " R5 write byte"},
            mem[a[5:0] + 6'(i)], wd[8*(n-1-i) +: 8]);
  endtask

  task automatic cfg(bit p16, int w, int ba, int ra, int am);
    port16 = p16; nwait = w; berr_at = ba; res_at = ra; avec_mode = am;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 19);
    cfg(1, 0, -1, -1, 0);
    repeat (3) @(negedge clk);
    chk(req_ready && !bus_strobe && !rsp_valid, "R1 reset", {req_ready, bus_strobe, rsp_valid}, 3'b100);
    rst_n = 1;
    cfg(1, 0, -1, -1, 0); run_op(2, 24'h10, 0, 0, 0, 2, 1, 0, 0, 0, "R3 long p16");
    cfg(0, 1, -1, -1, 0); run_op(2, 24'h20, 0, 0, 0, 4, 1, 0, 0, 0, "R4 R2 long p8");
    cfg(1, 0, -1, -1, 0); run_op(1, 24'h08, 1, 0, 32'h0000BEEF, 1, 1, 0, 0, 0, "R5 word wr p16");
    cfg(0, 2, -1, -1, 0); run_op(2, 24'h30, 1, 0, 32'h11223344, 4, 1, 0, 0, 0, "R4 R5 long wr p8");
    cfg(1, 0, -1, -1, 0); run_op(0, 24'h05, 0, 0, 0, 1, 1, 0, 0, 0, "R7 byte odd");
    cfg(1, 1, -1, -1, 0); run_op(1, 24'h07, 0, 0, 0, 2, 1, 0, 0, 0, "R7 word odd");
    cfg(1, 0, -1, -1, 0); run_op(2, 24'h13, 0, 0, 0, 3, 1, 0, 0, 0, "R7 R6 long odd");
    cfg(1, 0, 1, -1, 0);  run_op(2, 24'h10, 0, 0, 0, 2, 0, 1, 0, 0, "R8 berr");
    cfg(1, 0, -1, 0, 0);  run_op(1, 24'h02, 0, 0, 0, 1, 0, 1, 0, 0, "R9 reserved");
    cfg(1, 1, -1, -1, 1); run_op(0, 24'h00, 0, 1, 0, 1, 0, 0, 1, 0, "R10 avec iack");
    cfg(0, 2, -1, -1, 2); run_op(2, 24'h3A, 0, 0, 0, 4, 1, 0, 0, 0, "R10 avec ignored");
    cfg(1, 0, -1, -1, 0); run_op(0, 24'h0D, 1, 0, 32'h000000C3, 1, 1, 0, 0, 0, "R7 R5 byte wr odd");
    cfg(0, 0, -1, -1, 0); run_op(0, 24'h0B, 1, 0, 32'h0000005E, 1, 1, 0, 0, 0, "R4 byte wr p8");
    cfg(1, 0, -1, -1, 0); run_op(1, 24'h02, 0, 0, 0, 1, 1, 0, 0, 3, "R12 backpressure");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule